// File: doc/BRIEF.md
# March SS Memory Test Sequencer

This block tests a small synchronous single-port SRAM, such as a cache tag or data array, with a fixed word-oriented March SS sequence. After a start request it latches a background word. It then walks six elements over every address and issues one memory operation per clock. Each operation is a write or a read of either the background or its bitwise complement. Every read is compared with the word the sequence expects. The first mismatch is recorded with its address and element number.

To cover several data backgrounds, the surrounding logic starts one run per background. For each run it presents a new word on the background input and waits for the done pulse. The fail flag, failing address and failing element stay valid from the end of a run until the next run is accepted.

Top module: `march_ss_engine`

## Requirements
- R1: After reset, busy, done, fail and memory write enable are all low.
- R2: A start request is accepted only while the engine is idle. A start pulse during a run neither restarts nor shortens it, and the operation stream continues unchanged.
- R3: Operations are issued on consecutive cycles, one per cycle, starting in the cycle after the start is accepted. A run issues 22 operations per address, DEPTH×22 in total.
- R4: The element order is fixed: M0 (1 op), M1 (5), M2 (5), M3 (5), M4 (5), M5 (1). M0, M1, M2 and M5 visit addresses 0 up to DEPTH-1. M3 and M4 visit DEPTH-1 down to 0. All operations of an element at one address complete before the next address.
- R5: Operation lists, where B is the latched background and ~B its complement. M0 writes B. M1 and M3: read B, read B, write B, read B, write ~B. M2 and M4: read ~B, read ~B, write ~B, read ~B, write B. M5 reads B. A write drives the word on the write-data port with write enable high. A read drives write enable low.
- R6: Read data is compared one cycle after the read is issued. The first mismatch sets the fail flag and latches its address and element index (0 to 5). Later mismatches do not change these. The results hold until the next accepted start clears them.
- R7: Done is high for exactly one cycle, two cycles after the last M5 operation is issued. Fail outputs are final in that cycle, and busy falls in the following cycle.
- R8: Write enable is never high while the engine is not busy.
- R9: The background is captured when the start is accepted. Changes on the background input during a run have no effect on written or expected words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, sampled when idle |
| bg_i | input | DATA_W | Data background for the run |
| busy_o | output | 1 | Run in progress (including flush and done cycles) |
| done_o | output | 1 | One-cycle end-of-run pulse |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_we_o | output | 1 | Memory write enable |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_rdata_i | input | DATA_W | Memory read data, valid one cycle after a read |
| fail_o | output | 1 | Sticky mismatch flag |
| fail_addr_o | output | ADDR_W | Address of the first mismatch |
| fail_elem_o | output | 3 | Element index of the first mismatch |

## Verification
The assertions assume the memory returns read data exactly one cycle after the read is issued. They also assume start is a level that may be asserted at any time, including mid-run. The bench provides such a memory as a behavioural array with an optional injected stuck-at bit. It deliberately pulses start and changes the background in the middle of some runs, so the ignore rules are exercised and not merely assumed.

// File: rtl/march_ss_pkg.sv
package march_ss_pkg;

  localparam int NUM_ELEM     = 6;
  localparam int OPS_PER_ADDR = 22;
  localparam int ELEM_W       = 3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_FLUSH = 2'd2,
    ST_DONE  = 2'd3
  } eng_state_t;

  typedef struct packed {
    logic wr;   // 1 = write, 0 = read
    logic inv;  // 1 = complemented background
  } mop_t;

  // Number of operations per address in an element
  function automatic logic [2:0] elem_len(input logic [ELEM_W-1:0] e);
    return (e == 3'd0 || e == 3'd5) ? 3'd1 : 3'd5;
  endfunction

  // Descending address order for M3 and M4
  function automatic logic elem_desc(input logic [ELEM_W-1:0] e);
    return (e == 3'd3 || e == 3'd4);
  endfunction

  // Operation decode for element e, operation slot i
  function automatic mop_t elem_op(input logic [ELEM_W-1:0] e, input logic [2:0] i);
    mop_t o;
    o.wr  = 1'b0;
    o.inv = 1'b0;
    case (e)
      3'd0: o.wr = 1'b1;
      3'd1, 3'd3: begin
        o.wr  = (i == 3'd2 || i == 3'd4);
        o.inv = (i == 3'd4);
      end
      3'd2, 3'd4: begin
        o.wr  = (i == 3'd2 || i == 3'd4);
        o.inv = (i != 3'd4);
      end
      default: ;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/march_seq.sv
module march_seq
  import march_ss_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic              advance,
  output logic [ELEM_W-1:0] elem,
  output logic [2:0]        op_idx,
  output logic [ADDR_W-1:0] addr,
  output logic              last_op
);

  localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(DEPTH - 1);

  function automatic logic [ADDR_W-1:0] first_addr(input logic [ELEM_W-1:0] e);
    return elem_desc(e) ? TOP_ADDR : '0;
  endfunction

  function automatic logic [ADDR_W-1:0] final_addr(input logic [ELEM_W-1:0] e);
    return elem_desc(e) ? '0 : TOP_ADDR;
  endfunction

  logic op_wrap;
  logic addr_wrap;

  assign op_wrap   = (op_idx == elem_len(elem) - 3'd1);
  assign addr_wrap = (addr == final_addr(elem));
  assign last_op   = op_wrap && addr_wrap && (elem == ELEM_W'(NUM_ELEM - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elem   <= '0;
      op_idx <= '0;
      addr   <= '0;
    end else if (launch) begin
      elem   <= '0;
      op_idx <= '0;
      addr   <= '0;
    end else if (advance) begin
      if (op_wrap) begin
        op_idx <= '0;
        if (addr_wrap) begin
          elem <= elem + 1'b1;
          addr <= first_addr(elem + 1'b1);
        end else if (elem_desc(elem)) begin
          addr <= addr - 1'b1;
        end else begin
          addr <= addr + 1'b1;
        end
      end else begin
        op_idx <= op_idx + 1'b1;
      end
    end
  end

endmodule

// File: rtl/march_cmp.sv
module march_cmp
  import march_ss_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              issue_rd,
  input  logic [DATA_W-1:0] issue_exp,
  input  logic [ADDR_W-1:0] issue_addr,
  input  logic [ELEM_W-1:0] issue_elem,
  input  logic [DATA_W-1:0] rdata,
  output logic              mismatch,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [ELEM_W-1:0] fail_elem
);

  logic              v_q;
  logic [DATA_W-1:0] exp_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ELEM_W-1:0] elem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q    <= 1'b0;
      exp_q  <= '0;
      addr_q <= '0;
      elem_q <= '0;
    end else begin
      v_q    <= issue_rd;
      exp_q  <= issue_exp;
      addr_q <= issue_addr;
      elem_q <= issue_elem;
    end
  end

  assign mismatch = v_q && (rdata != exp_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail      <= 1'b0;
      fail_addr <= '0;
      fail_elem <= '0;
    end else if (clear) begin
      fail      <= 1'b0;
      fail_addr <= '0;
      fail_elem <= '0;
    end else if (mismatch && !fail) begin
      fail      <= 1'b1;
      fail_addr <= addr_q;
      fail_elem <= elem_q;
    end
  end

endmodule

// File: rtl/march_ss_engine.sv
module march_ss_engine
  import march_ss_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DATA_W-1:0] bg_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              fail_o,
  output logic [ADDR_W-1:0] fail_addr_o,
  output logic [ELEM_W-1:0] fail_elem_o
);

  eng_state_t        state_q;
  logic [DATA_W-1:0] bg_q;

  // Named internal events
  logic              launch;
  logic              op_issue;
  logic              read_issue;
  logic              last_op;
  logic              cmp_mismatch;

  logic [ELEM_W-1:0] elem;
  logic [2:0]        op_idx;
  logic [ADDR_W-1:0] addr;
  mop_t              cur_op;
  logic [DATA_W-1:0] op_word;

  assign launch     = (state_q == ST_IDLE) && start_i;
  assign op_issue   = (state_q == ST_RUN);
  assign cur_op     = elem_op(elem, op_idx);
  assign read_issue = op_issue && !cur_op.wr;
  assign op_word    = cur_op.inv ? ~bg_q : bg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bg_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_RUN;
          bg_q    <= bg_i;
        end
        ST_RUN:   if (last_op) state_q <= ST_FLUSH;
        ST_FLUSH: state_q <= ST_DONE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  march_seq #(
    .DEPTH (DEPTH),
    .ADDR_W(ADDR_W)
  ) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .launch (launch),
    .advance(op_issue),
    .elem   (elem),
    .op_idx (op_idx),
    .addr   (addr),
    .last_op(last_op)
  );

  march_cmp #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) u_cmp (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (launch),
    .issue_rd  (read_issue),
    .issue_exp (op_word),
    .issue_addr(addr),
    .issue_elem(elem),
    .rdata     (mem_rdata_i),
    .mismatch  (cmp_mismatch),
    .fail      (fail_o),
    .fail_addr (fail_addr_o),
    .fail_elem (fail_elem_o)
  );

  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = (state_q == ST_DONE);
  assign mem_addr_o  = addr;
  assign mem_we_o    = op_issue && cur_op.wr;
  assign mem_wdata_o = op_word;

endmodule

// File: rtl/march_ss_checker.sv
module march_ss_checker #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              mem_we_o,
  input logic              fail_o,
  input logic [ADDR_W-1:0] fail_addr_o,
  input logic              op_issue,
  input logic              last_op,
  input logic              cmp_mismatch
);

  a_r8_no_write_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !mem_we_o);

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));

  a_r7_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (op_issue && last_op) |-> ##2 done_o);

  a_r2_run_not_cut: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> busy_o);

  a_r6_first_mismatch_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_mismatch && !fail_o) |=> fail_o);

  a_r6_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_o && !(start_i && !busy_o)) |=> (fail_o && $stable(fail_addr_o)));

endmodule

bind march_ss_engine march_ss_checker #(
  .ADDR_W(ADDR_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .mem_we_o    (mem_we_o),
  .fail_o      (fail_o),
  .fail_addr_o (fail_addr_o),
  .op_issue    (op_issue),
  .last_op     (last_op),
  .cmp_mismatch(cmp_mismatch)
);

// File: tb/tb_march_ss_engine.sv
`timescale 1ns/1ps
module tb_march_ss_engine;

  localparam int D  = 16;
  localparam int DW = 8;
  localparam int AW = $clog2(D);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [DW-1:0] bg_i = '0;
  logic          busy_o, done_o, mem_we_o, fail_o;
  logic [AW-1:0] mem_addr_o, fail_addr_o;
  logic [DW-1:0] mem_wdata_o;
  logic [DW-1:0] mem_rdata_i;
  logic [2:0]    fail_elem_o;

  int n_checks = 0;
  int n_fails  = 0;

  always #2 clk = ~clk;

  march_ss_engine #(.DEPTH(D), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .bg_i(bg_i),
    .busy_o(busy_o), .done_o(done_o), .mem_addr_o(mem_addr_o),
    .mem_we_o(mem_we_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
    .fail_o(fail_o), .fail_addr_o(fail_addr_o), .fail_elem_o(fail_elem_o)
  );

  // Behavioural memory with optional stuck-at bit
  logic [DW-1:0] mem [D];
  logic          flt_en  = 1'b0;
  int            flt_adr = 0;
  int            flt_bit = 0;
  logic          flt_val = 1'b0;
  logic [DW-1:0] rd_view;

  always_comb begin
    rd_view = mem[mem_addr_o];
    if (flt_en && int'(mem_addr_o) == flt_adr) rd_view[flt_bit] = flt_val;
  end

  always_ff @(posedge clk) begin
    if (mem_we_o) mem[mem_addr_o] <= mem_wdata_o;
    mem_rdata_i <= rd_view;
  end

  // Bench restatement of the sequence
  function automatic int b_len(int e);
    return (e == 0 || e == 5) ? 1 : 5;
  endfunction
  function automatic bit b_wr(int e, int i);
    if (e == 0) return 1;
    if (e == 5) return 0;
    return (i == 2) || (i == 4);
  endfunction
  function automatic bit b_inv(int e, int i);
    if (e == 2 || e == 4) return i < 4;
    if (e == 1 || e == 3) return i == 4;
    return 0;
  endfunction
  function automatic int b_addr(int e, int k);
    return (e == 3 || e == 4) ? D - 1 - k : k;
  endfunction

  task automatic check(bit ok, string tag, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_test(logic [DW-1:0] bg, bit fen, int fa, int fb, bit fv, bit disturb);
    bit            exp_fail = 0;
    int            exp_fa = 0, exp_fe = 0;
    int            k = 0;
    bit            trace_ok = 1;
    logic [DW-1:0] w;
    flt_en = fen; flt_adr = fa; flt_bit = fb; flt_val = fv;
    // expected first failure
    if (fen) begin
      for (int e = 0; e < 6 && !exp_fail; e++)
        for (int a = 0; a < D && !exp_fail; a++)
          for (int i = 0; i < b_len(e) && !exp_fail; i++)
            if (!b_wr(e, i) && b_addr(e, a) == fa) begin
              w = b_inv(e, i) ? ~bg : bg;
              if (w[fb] != fv) begin exp_fail = 1; exp_fa = fa; exp_fe = e; end
            end
    end
    @(negedge clk);
    bg_i = bg; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int e = 0; e < 6; e++)
      for (int a = 0; a < D; a++)
        for (int i = 0; i < b_len(e); i++) begin
          w = b_inv(e, i) ? ~bg : bg;
          // R3 R4 R5 R9: one op per cycle in the expected order and data
          if (mem_we_o !== b_wr(e, i) || int'(mem_addr_o) != b_addr(e, a) ||
              (b_wr(e, i) && mem_wdata_o !== w) || done_o !== 1'b0 || busy_o !== 1'b1) begin
            if (trace_ok)
              check(0, $sformatf("R3/R4/R5 op e%0d a%0d i%0d", e, a, i),
                    {mem_we_o, mem_addr_o, mem_wdata_o},
                    {b_wr(e, i), AW'(b_addr(e, a)), w});
            trace_ok = 0;
          end
          if (disturb && k == 40) begin start_i = 1'b1; bg_i = ~bg; end
          if (disturb && k == 41) start_i = 1'b0;
          k++;
          @(negedge clk);
        end
    check(trace_ok, "R4 R5 operation trace", trace_ok, 1);
    if (disturb) check(trace_ok, "R2 R9 mid-run start and background change ignored", trace_ok, 1);
    check(k == 22 * D, "R3 op count", k, 22 * D);
    check(done_o == 1'b0, "R7 done low in flush cycle", done_o, 0);
    @(negedge clk);
    check(done_o == 1'b1, "R7 done pulse", done_o, 1);
    check(fail_o == exp_fail, "R6 fail flag", fail_o, exp_fail);
    if (exp_fail) begin
      check(int'(fail_addr_o) == exp_fa, "R6 fail address", fail_addr_o, exp_fa);
      check(int'(fail_elem_o) == exp_fe, "R6 fail element", fail_elem_o, exp_fe);
    end
    @(negedge clk);
    check(done_o == 1'b0 && busy_o == 1'b0, "R7 done single cycle, busy falls",
          {done_o, busy_o}, 0);
    check(mem_we_o == 1'b0, "R8 no write when idle", mem_we_o, 0);
    check(fail_o == exp_fail, "R6 fail held after done", fail_o, exp_fail);
  endtask

  initial begin
    #(4 * 200000);
    n_fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check(busy_o == 0 && done_o == 0 && fail_o == 0 && mem_we_o == 0,
          "R1 reset state", {busy_o, done_o, fail_o, mem_we_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy_o == 0 && mem_we_o == 0, "R1 idle after reset release", {busy_o, mem_we_o}, 0);

    // Directed corner cases
    run_test(8'h00, 0, 0, 0, 0, 0);
    run_test(8'hA5, 1, 0, 0, 1'b0, 0);       // bg bit 1 vs stuck 0: fails in M1 at addr 0
    run_test(8'h5A, 1, D - 1, 3, 1'b1, 0);   // bg bit 1 == stuck 1: fails in M2 at top addr
    run_test(8'hFF, 0, 0, 0, 0, 1);          // clears fail, mid-run disturbance
    run_test(8'h3C, 1, 7, 7, 1'b1, 1);       // fault plus disturbance

    // Random runs
    for (int r = 0; r < 8; r++) begin
      logic [DW-1:0] rbg = DW'($urandom);
      bit            rfen = ($urandom % 3) != 0;
      int            rfa = $urandom % D;
      int            rfb = $urandom % DW;
      bit            rfv = $urandom % 2;
      bit            rdis = $urandom % 2;
      run_test(rbg, rfen, rfa, rfb, rfv, rdis);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule